// File: doc/BRIEF.md
# Key-Protected Watchdog Timer

This block is a memory-mapped watchdog timer on a simple synchronous register bus. The bus has a byte address, a write strobe, 16-bit write data and a combinational 16-bit read port. A down-counter holds the remaining time in units of one tick, where a tick is one strobe on `tick_i` (nominally 10 ms). The counter decrements only while the watchdog is running. When it runs out, the block emits a single-cycle reset request and records a timed-out status code. That status code survives the system reset the request causes, because it is cleared only at power-on or by a key write. One tick before expiry, an early-warning interrupt event is raised. The event can be masked, forced and acknowledged.

Software cannot act on the control registers by writing plain bits. Each action takes a specific 16-bit key value: feeding, resuming, clearing status, and stopping the timer. Stopping takes two keys written back to back to two different registers. The run state is held in a three-state controller:
- `ST_HALTED`: the counter is frozen.
- `ST_RUNNING`: the counter decrements on each tick.
- `ST_ARMED`: the first stop key has been accepted and the counter still runs.

The transitions are:
- `T_RESUME`: halted to running, on the resume key.
- `T_ARM`: running to armed, on the first stop key.
- `T_REARM`: armed to armed, on a repeated first stop key.
- `T_STOP`: armed to halted, on the second stop key as the very next write.
- `T_ABANDON`: armed to running, on any other write.

A debug input can pause counting unless an override bit is set.

Top module: `keyed_watchdog`

## Requirements
- R1: After reset the timer is halted, and address 0x0C reads 0xDABE. The timeout register and the count both equal DEFAULT_TIMEOUT. The event, mask, force and debug-override bits are 0, and `rst_req_o` and `irq_o` are low.
- R2: Byte offsets are as follows. Writes to unmapped offsets change nothing, and reads of unmapped offsets return 0.
  - 0x00 feed, 0x08 stop key 1 and 0x1C resume are write-only and read 0.
  - 0x04 timeout.
  - 0x0C stop key 2 / run status.
  - 0x10 status.
  - 0x14 count.
  - 0x18 debug.
  - 0x20 event, 0x24 mask and 0x28 force each use bit 0 only.
- R3: Writing 0xFEED to 0x00 reloads the count from the timeout register (bits 14:0) in the following cycle. Any other value written to 0x00 has no effect.
- R4: While running, each tick lowers the count by one. While halted, ticks leave the count unchanged.
- R5: The timer stops only when 0x2BAD is written to 0x08 and then 0xCAFE is written to 0x0C as the very next write. Any other intervening write, or a wrong value, abandons the sequence. Address 0x0C reads 0x0000 while running or armed, and 0xDABE while halted.
- R6: Writing 0xACED to 0x1C while halted starts the timer and reloads the count from the timeout register. While running, the resume key has no effect on the count.
- R7: A tick that arrives while running with the count at 1 or less reloads the count from the timeout register. It also pulses `rst_req_o` high for exactly one cycle, one cycle after that tick, and sets the status code.
- R8: Address 0x10 reads 0xCFE8 after an expiry and 0x0000 otherwise. The code survives `rst_ni`. It is cleared by `por_ni` or by writing 0xE8B4, and other values written there are ignored.
- R9: Count readback at 0x14 has bit 15 set during the cycle after the count register changed, and bits 14:0 hold the count.
- R10: A tick that arrives while running with the count at 2 sets event bit 0. Writing 1 to bit 0 of 0x20 acknowledges the event, and a set condition in the same cycle wins. `irq_o` equals event AND mask bit 0.
- R11: While force bit 0 (0x28) is 1, the event is set again every cycle.
- R12: At 0x18, bit 1 reads `dbg_mode_i` and bit 0 is a writable override. While `dbg_mode_i` is 1 and the override is 0, counting pauses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous system reset |
| por_ni | input | 1 | Active-low asynchronous power-on reset (also clears status) |
| tick_i | input | 1 | One-cycle time-base strobe |
| dbg_mode_i | input | 1 | Debug mode indication |
| we_i | input | 1 | Register write strobe |
| addr_i | input | ADDR_W | Register byte address |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data for `addr_i` (combinational) |
| irq_o | output | 1 | Early-warning interrupt |
| rst_req_o | output | 1 | One-cycle reset request on expiry |

## Verification
The bench drives several write patterns into the stop path:
- The correct key pair.
- The pair with an unrelated register write between the keys.
- A wrong second key.
- A second key with no first key.

Only the first pattern may reach `ST_HALTED`, which separates strict ordering from mere key matching. Count behaviour is tried with ticks while running, while halted, in debug mode with and without the override, and with feed and resume writes of correct and wrong values. These patterns separate reload, hold and decrement. Expiry is approached with a small timeout, so that the warning tick, the acknowledge, the reset-request pulse and the status retention across `rst_ni` versus `por_ni` are each observed in their own cycle.

// File: rtl/wdg_pkg.sv
package wdg_pkg;

    localparam int unsigned DATA_W = 16;

    // register byte offsets
    localparam logic [7:0] OFS_FEED   = 8'h00;
    localparam logic [7:0] OFS_TMO    = 8'h04;
    localparam logic [7:0] OFS_STOP1  = 8'h08;
    localparam logic [7:0] OFS_STOP2  = 8'h0C;
    localparam logic [7:0] OFS_STAT   = 8'h10;
    localparam logic [7:0] OFS_COUNT  = 8'h14;
    localparam logic [7:0] OFS_DEBUG  = 8'h18;
    localparam logic [7:0] OFS_RESUME = 8'h1C;
    localparam logic [7:0] OFS_EVENT  = 8'h20;
    localparam logic [7:0] OFS_MASK   = 8'h24;
    localparam logic [7:0] OFS_FORCE  = 8'h28;

    // key values and status codes
    localparam logic [DATA_W-1:0] KEY_FEED    = 16'hFEED;
    localparam logic [DATA_W-1:0] KEY_STOP1   = 16'h2BAD;
    localparam logic [DATA_W-1:0] KEY_STOP2   = 16'hCAFE;
    localparam logic [DATA_W-1:0] KEY_RESUME  = 16'hACED;
    localparam logic [DATA_W-1:0] KEY_CLRSTAT = 16'hE8B4;
    localparam logic [DATA_W-1:0] CODE_HALTED = 16'hDABE;
    localparam logic [DATA_W-1:0] CODE_TIMED  = 16'hCFE8;

    typedef enum logic [1:0] {
        ST_HALTED  = 2'd0,
        ST_RUNNING = 2'd1,
        ST_ARMED   = 2'd2
    } wdg_state_e;

endpackage

// File: rtl/wdg_ctrl_fsm.sv
module wdg_ctrl_fsm
    import wdg_pkg::*;
(
    input  logic clk_i,
    input  logic rst_ni,
    input  logic wr_any_i,
    input  logic wr_stop1_i,
    input  logic wr_stop2_i,
    input  logic wr_resume_i,
    output logic running_o,
    output logic resume_ok_o
);

    wdg_state_e state_q, state_d;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) state_q <= ST_HALTED;
        else         state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_HALTED:  if (wr_resume_i) state_d = ST_RUNNING;      // T_RESUME
            ST_RUNNING: if (wr_stop1_i)  state_d = ST_ARMED;        // T_ARM
            ST_ARMED: begin
                if (wr_stop2_i)      state_d = ST_HALTED;           // T_STOP
                else if (wr_stop1_i) state_d = ST_ARMED;            // T_REARM
                else if (wr_any_i)   state_d = ST_RUNNING;          // T_ABANDON
            end
            default: state_d = ST_HALTED;
        endcase
    end

    always_comb begin
        running_o   = (state_q != ST_HALTED);
        resume_ok_o = (state_q == ST_HALTED) && wr_resume_i;
    end

endmodule

// File: rtl/wdg_down_counter.sv
module wdg_down_counter #(
    parameter int unsigned CNT_W     = 15,
    parameter int unsigned RESET_VAL = 6000
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             run_i,
    input  logic             tick_i,
    input  logic             reload_i,
    input  logic [CNT_W-1:0] load_val_i,
    output logic [CNT_W-1:0] count_o,
    output logic             changing_o,
    output logic             expire_o,
    output logic             warn_o
);

    logic [CNT_W-1:0] count_q;
    logic             chg_q;
    logic             step;

    assign step     = tick_i && run_i && !reload_i;
    assign expire_o = step && (count_q <= CNT_W'(1));
    assign warn_o   = step && (count_q == CNT_W'(2));

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            count_q <= CNT_W'(RESET_VAL);
            chg_q   <= 1'b0;
        end else if (reload_i) begin
            count_q <= load_val_i;
            chg_q   <= 1'b1;
        end else if (step) begin
            count_q <= (count_q <= CNT_W'(1)) ? load_val_i : count_q - CNT_W'(1);
            chg_q   <= 1'b1;
        end else begin
            chg_q   <= 1'b0;
        end
    end

    assign count_o    = count_q;
    assign changing_o = chg_q;

endmodule

// File: rtl/wdg_irq_unit.sv
module wdg_irq_unit (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic warn_i,
    input  logic wr_event_i,
    input  logic wr_mask_i,
    input  logic wr_force_i,
    input  logic wbit_i,
    output logic event_o,
    output logic mask_o,
    output logic force_o,
    output logic irq_o
);

    logic event_q, mask_q, force_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            event_q <= 1'b0;
            mask_q  <= 1'b0;
            force_q <= 1'b0;
        end else begin
            if (warn_i || force_q)         event_q <= 1'b1;
            else if (wr_event_i && wbit_i) event_q <= 1'b0;
            if (wr_mask_i)  mask_q  <= wbit_i;
            if (wr_force_i) force_q <= wbit_i;
        end
    end

    assign event_o = event_q;
    assign mask_o  = mask_q;
    assign force_o = force_q;
    assign irq_o   = event_q && mask_q;

endmodule

// File: rtl/keyed_watchdog.sv
module keyed_watchdog
    import wdg_pkg::*;
#(
    parameter int unsigned ADDR_W          = 6,
    parameter int unsigned CNT_W           = 15,
    parameter int unsigned DEFAULT_TIMEOUT = 6000
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              por_ni,
    input  logic              tick_i,
    input  logic              dbg_mode_i,
    input  logic              we_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [15:0]       wdata_i,
    output logic [15:0]       rdata_o,
    output logic              irq_o,
    output logic              rst_req_o
);

    localparam int unsigned CNT_RB_W = DATA_W - 1;

    logic [CNT_W-1:0] timeout_q;
    logic [CNT_W-1:0] count_w;
    logic             timed_out_q;
    logic             ovr_q;
    logic             rst_req_q;
    logic             running, resume_ok, reload, run_gated;
    logic             changing, expire, warn;
    logic             ev, msk, frc;

    // address decode (write side)
    logic sel_feed, sel_tmo, sel_stop1, sel_stop2, sel_stat;
    logic sel_dbg, sel_resume, sel_event, sel_mask, sel_force;

    always_comb begin
        sel_feed   = we_i && (addr_i == ADDR_W'(OFS_FEED));
        sel_tmo    = we_i && (addr_i == ADDR_W'(OFS_TMO));
        sel_stop1  = we_i && (addr_i == ADDR_W'(OFS_STOP1));
        sel_stop2  = we_i && (addr_i == ADDR_W'(OFS_STOP2));
        sel_stat   = we_i && (addr_i == ADDR_W'(OFS_STAT));
        sel_dbg    = we_i && (addr_i == ADDR_W'(OFS_DEBUG));
        sel_resume = we_i && (addr_i == ADDR_W'(OFS_RESUME));
        sel_event  = we_i && (addr_i == ADDR_W'(OFS_EVENT));
        sel_mask   = we_i && (addr_i == ADDR_W'(OFS_MASK));
        sel_force  = we_i && (addr_i == ADDR_W'(OFS_FORCE));
    end

    wdg_ctrl_fsm u_fsm (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .wr_any_i    (we_i),
        .wr_stop1_i  (sel_stop1 && (wdata_i == KEY_STOP1)),
        .wr_stop2_i  (sel_stop2 && (wdata_i == KEY_STOP2)),
        .wr_resume_i (sel_resume && (wdata_i == KEY_RESUME)),
        .running_o   (running),
        .resume_ok_o (resume_ok)
    );

    assign reload    = (sel_feed && (wdata_i == KEY_FEED)) || resume_ok;
    assign run_gated = running && !(dbg_mode_i && !ovr_q);

    wdg_down_counter #(
        .CNT_W     (CNT_W),
        .RESET_VAL (DEFAULT_TIMEOUT)
    ) u_cnt (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .run_i      (run_gated),
        .tick_i     (tick_i),
        .reload_i   (reload),
        .load_val_i (timeout_q),
        .count_o    (count_w),
        .changing_o (changing),
        .expire_o   (expire),
        .warn_o     (warn)
    );

    wdg_irq_unit u_irq (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .warn_i     (warn),
        .wr_event_i (sel_event),
        .wr_mask_i  (sel_mask),
        .wr_force_i (sel_force),
        .wbit_i     (wdata_i[0]),
        .event_o    (ev),
        .mask_o     (msk),
        .force_o    (frc),
        .irq_o      (irq_o)
    );

    // system-reset domain registers
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            timeout_q <= CNT_W'(DEFAULT_TIMEOUT);
            ovr_q     <= 1'b0;
            rst_req_q <= 1'b0;
        end else begin
            if (sel_tmo) timeout_q <= wdata_i[CNT_W-1:0];
            if (sel_dbg) ovr_q     <= wdata_i[0];
            rst_req_q <= expire;
        end
    end

    // power-on domain: status survives the reset it requests
    always_ff @(posedge clk_i or negedge por_ni) begin
        if (!por_ni)                                  timed_out_q <= 1'b0;
        else if (expire)                              timed_out_q <= 1'b1;
        else if (sel_stat && (wdata_i == KEY_CLRSTAT)) timed_out_q <= 1'b0;
    end

    assign rst_req_o = rst_req_q;

    // read mux
    always_comb begin
        rdata_o = '0;
        unique case (addr_i)
            ADDR_W'(OFS_TMO):   rdata_o = DATA_W'(timeout_q);
            ADDR_W'(OFS_STOP2): rdata_o = running ? 16'h0000 : CODE_HALTED;
            ADDR_W'(OFS_STAT):  rdata_o = timed_out_q ? CODE_TIMED : 16'h0000;
            ADDR_W'(OFS_COUNT): rdata_o = {changing, CNT_RB_W'(count_w)};
            ADDR_W'(OFS_DEBUG): rdata_o = {14'd0, dbg_mode_i, ovr_q};
            ADDR_W'(OFS_EVENT): rdata_o = {15'd0, ev};
            ADDR_W'(OFS_MASK):  rdata_o = {15'd0, msk};
            ADDR_W'(OFS_FORCE): rdata_o = {15'd0, frc};
            default:            rdata_o = '0;
        endcase
    end

endmodule

// File: rtl/keyed_watchdog_chk.sv
module keyed_watchdog_chk
    import wdg_pkg::*;
#(
    parameter int unsigned ADDR_W = 6,
    parameter int unsigned CNT_W  = 15
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic              por_ni,
    input logic              we_i,
    input logic [ADDR_W-1:0] addr_i,
    input logic [15:0]       wdata_i,
    input logic              rst_req_o,
    input logic              running,
    input logic              reload,
    input logic              timed_out_q,
    input logic [CNT_W-1:0]  count_w
);

    p_req_single_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rst_req_o |=> !rst_req_o);

    p_req_has_status_r7: assert property (@(posedge clk_i) disable iff (!rst_ni || !por_ni)
        rst_req_o |-> timed_out_q);

    p_status_rise_r8: assert property (@(posedge clk_i) disable iff (!rst_ni || !por_ni)
        $rose(timed_out_q) |-> rst_req_o);

    p_halted_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!running && !reload) |=> $stable(count_w));

    p_stop_key_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!running && $past(running)) |->
            $past(we_i && (addr_i == ADDR_W'(OFS_STOP2)) && (wdata_i == KEY_STOP2)));

    p_resume_key_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(running) |->
            $past(we_i && (addr_i == ADDR_W'(OFS_RESUME)) && (wdata_i == KEY_RESUME)));

endmodule

bind keyed_watchdog keyed_watchdog_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .por_ni      (por_ni),
    .we_i        (we_i),
    .addr_i      (addr_i),
    .wdata_i     (wdata_i),
    .rst_req_o   (rst_req_o),
    .running     (running),
    .reload      (reload),
    .timed_out_q (timed_out_q),
    .count_w     (count_w)
);

// File: tb/keyed_watchdog_tb.sv
module keyed_watchdog_tb;

    localparam int ADDR_W = 6;

    logic              clk_i = 1'b0;
    logic              rst_ni = 1'b0, por_ni = 1'b0;
    logic              tick_i = 1'b0, dbg_mode_i = 1'b0, we_i = 1'b0;
    logic [ADDR_W-1:0] addr_i = '0;
    logic [15:0]       wdata_i = '0;
    logic [15:0]       rdata_o;
    logic              irq_o, rst_req_o;

    int n_chk = 0, n_err = 0;
    bit done = 0;

    keyed_watchdog u_dut (
        .clk_i(clk_i), .rst_ni(rst_ni), .por_ni(por_ni), .tick_i(tick_i),
        .dbg_mode_i(dbg_mode_i), .we_i(we_i), .addr_i(addr_i), .wdata_i(wdata_i),
        .rdata_o(rdata_o), .irq_o(irq_o), .rst_req_o(rst_req_o)
    );

    always #5 clk_i = ~clk_i;

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [15:0] d);
        @(negedge clk_i);
        we_i = 1'b1; addr_i = ADDR_W'(a); wdata_i = d;
        @(negedge clk_i);
        we_i = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [15:0] v);
        addr_i = ADDR_W'(a);
        #1 v = rdata_o;
    endtask

    task automatic tick();
        @(negedge clk_i);
        tick_i = 1'b1;
        @(negedge clk_i);
        tick_i = 1'b0;
    endtask

    task automatic cnt(output logic [15:0] v);
        logic [15:0] r;
        rd(8'h14, r);
        v = r & 16'h7FFF;
    endtask

    task automatic t_reset();
        logic [15:0] v;
        rd(8'h0C, v); check("R1 run status", v, 16'hDABE);
        rd(8'h04, v); check("R1 timeout", v, 16'd6000);
        cnt(v);       check("R1 count", v, 16'd6000);
        rd(8'h20, v); check("R1 event", v, 16'h0);
        rd(8'h10, v); check("R1 status", v, 16'h0);
        check("R1 rst_req", {15'd0, rst_req_o}, 16'h0);
        check("R1 irq", {15'd0, irq_o}, 16'h0);
    endtask

    task automatic t_regmap();
        logic [15:0] v;
        wr(8'h24, 16'h0001);
        rd(8'h24, v); check("R2 mask readback", v, 16'h0001);
        wr(8'h24, 16'h0000);
        wr(8'h2C, 16'hFFFF);
        rd(8'h2C, v); check("R2 unmapped read", v, 16'h0);
        rd(8'h00, v); check("R2 feed reads 0", v, 16'h0);
        rd(8'h04, v); check("R2 unmapped write no effect", v, 16'd6000);
    endtask

    task automatic t_start();
        logic [15:0] v;
        wr(8'h04, 16'd5);
        wr(8'h1C, 16'hACED);
        rd(8'h0C, v); check("R6 running status", v, 16'h0000);
        rd(8'h14, v); check("R9 changing flag after reload", v, 16'h8005);
        @(negedge clk_i);
        rd(8'h14, v); check("R9 stable flag", v, 16'h0005);
        tick();
        cnt(v); check("R4 decrement", v, 16'd4);
        wr(8'h1C, 16'hACED);
        cnt(v); check("R6 resume ignored while running", v, 16'd4);
    endtask

    task automatic t_feed();
        logic [15:0] v;
        wr(8'h00, 16'h1234);
        cnt(v); check("R3 wrong feed ignored", v, 16'd4);
        wr(8'h00, 16'hFEED);
        cnt(v); check("R3 feed reload", v, 16'd5);
    endtask

    task automatic t_debug();
        logic [15:0] v;
        dbg_mode_i = 1'b1;
        tick();
        cnt(v); check("R12 paused in debug", v, 16'd5);
        rd(8'h18, v); check("R12 debug bit", v, 16'h0002);
        wr(8'h18, 16'h0001);
        rd(8'h18, v); check("R12 override readback", v, 16'h0003);
        tick();
        cnt(v); check("R12 counts with override", v, 16'd4);
        wr(8'h18, 16'h0000);
        dbg_mode_i = 1'b0;
    endtask

    task automatic t_expiry();
        logic [15:0] v;
        wr(8'h24, 16'h0001);
        wr(8'h04, 16'd3);
        wr(8'h00, 16'hFEED);
        tick();
        rd(8'h20, v); check("R10 no early event", v, 16'h0);
        tick();
        cnt(v); check("R4 count at 1", v, 16'd1);
        rd(8'h20, v); check("R10 warning event", v, 16'h0001);
        check("R10 irq high", {15'd0, irq_o}, 16'h1);
        wr(8'h20, 16'h0001);
        rd(8'h20, v); check("R10 ack clears", v, 16'h0);
        check("R10 irq low", {15'd0, irq_o}, 16'h0);
        check("R7 no request yet", {15'd0, rst_req_o}, 16'h0);
        tick();
        check("R7 request pulse", {15'd0, rst_req_o}, 16'h1);
        cnt(v); check("R7 reload on expiry", v, 16'd3);
        rd(8'h10, v); check("R8 timed-out code", v, 16'hCFE8);
        @(negedge clk_i);
        check("R7 pulse one cycle", {15'd0, rst_req_o}, 16'h0);
    endtask

    task automatic t_survive();
        logic [15:0] v;
        @(negedge clk_i); rst_ni = 1'b0;
        @(negedge clk_i); @(negedge clk_i); rst_ni = 1'b1;
        rd(8'h10, v); check("R8 status survives rst_ni", v, 16'hCFE8);
        rd(8'h0C, v); check("R1 halted after rst_ni", v, 16'hDABE);
        wr(8'h10, 16'h1111);
        rd(8'h10, v); check("R8 wrong clear ignored", v, 16'hCFE8);
        wr(8'h10, 16'hE8B4);
        rd(8'h10, v); check("R8 key clear", v, 16'h0);
    endtask

    task automatic t_stop();
        logic [15:0] v, c0;
        wr(8'h1C, 16'hACED);
        wr(8'h08, 16'h2BAD);
        rd(8'h0C, v); check("R5 armed still running", v, 16'h0000);
        wr(8'h0C, 16'hCAFE);
        rd(8'h0C, v); check("R5 stop sequence", v, 16'hDABE);
        cnt(c0);
        tick();
        cnt(v); check("R4 halted holds count", v, c0);
        wr(8'h1C, 16'hACED);
        wr(8'h08, 16'h2BAD);
        wr(8'h04, 16'd9);
        wr(8'h0C, 16'hCAFE);
        rd(8'h0C, v); check("R5 intervening write abandons", v, 16'h0000);
        wr(8'h08, 16'h2BAD);
        wr(8'h0C, 16'hCAFF);
        wr(8'h0C, 16'hCAFE);
        rd(8'h0C, v); check("R5 wrong key abandons", v, 16'h0000);
        wr(8'h08, 16'h2BAD);
        wr(8'h08, 16'h2BAD);
        wr(8'h0C, 16'hCAFE);
        rd(8'h0C, v); check("R5 repeated key1 then key2", v, 16'hDABE);
    endtask

    task automatic t_force();
        logic [15:0] v;
        wr(8'h24, 16'h0001);
        wr(8'h28, 16'h0001);
        @(negedge clk_i);
        rd(8'h20, v); check("R11 forced event", v, 16'h0001);
        wr(8'h20, 16'h0001);
        rd(8'h20, v); check("R11 force overrides ack", v, 16'h0001);
        wr(8'h24, 16'h0000);
        check("R10 masked irq", {15'd0, irq_o}, 16'h0);
        wr(8'h28, 16'h0000);
        wr(8'h20, 16'h0001);
        rd(8'h20, v); check("R11 cleared after release", v, 16'h0);
    endtask

    task automatic t_por();
        logic [15:0] v;
        wr(8'h04, 16'd1);
        wr(8'h1C, 16'hACED);
        tick();
        check("R7 expiry at count 1", {15'd0, rst_req_o}, 16'h1);
        rd(8'h10, v); check("R8 status set", v, 16'hCFE8);
        @(negedge clk_i); por_ni = 1'b0; rst_ni = 1'b0;
        @(negedge clk_i); por_ni = 1'b1; rst_ni = 1'b1;
        rd(8'h10, v); check("R8 por clears status", v, 16'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk_i);
        por_ni = 1'b1; rst_ni = 1'b1;
        @(negedge clk_i);
        t_reset();
        t_regmap();
        t_start();
        t_feed();
        t_debug();
        t_expiry();
        t_survive();
        t_stop();
        t_force();
        t_por();
        done = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk_i);
        if (!done) begin
            n_chk++; n_err++;
            $display("FAIL watchdog expired: actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

endmodule